// File: doc/BRIEF.md
# Baud Divisor Pair Search Engine

This block picks the settings for a two-stage serial clock divider. Given the rate of the input clock and the requested serial bit rate, it works out how far the clock must be divided. It then chooses a 2-bit prescaler index and a 4-bit scaler index whose combined division is the first in a fixed search order that reaches or exceeds that ratio. Division by the requested rate is done with a one-bit-per-cycle restoring divider. The candidate pairs are then tested one per clock cycle.

A host pulses `start` with both rates applied. It waits for the one-cycle `done` pulse and then reads the indices, which hold until the next successful search. If no pair is large enough, the largest pair is returned and `sat` pulses with `done`. A requested rate of zero is refused: `err` pulses with `done` and the indices stay as they were.

Top module: `baud_search_engine`

## Requirements
- R1: The needed ratio is floor(floor(clk_rate / 2) / target_rate), using unsigned integer arithmetic. An odd clock rate therefore loses its lowest bit before the division.
- R2: Prescaler index 0, 1, 2 and 3 selects a factor of 2, 3, 5 and 7.
- R3: Scaler indices 0 to 3 select 2, 4, 6 and 8. Scaler index n, for n from 4 to 15, selects 2 to the power n.
- R4: Pairs are tried with the prescaler index as the outer, slower-moving loop and the scaler index as the inner loop, both counting up from 0. The result is the first pair whose factor product is at least the ratio. A ratio of 0 or 1 yields pair (0,0).
- R5: If no pair reaches the ratio, the result is prescaler index 3 with scaler index 15, and `sat` is high in the `done` cycle. An exact match by pair (3,15) does not raise `sat`.
- R6: A start with `target_rate` equal to 0 is answered in the cycle after the accepting edge with `done` and `err` high and `busy` low. `pre_idx` and `scl_idx` are unchanged.
- R7: For a non-zero rate, `done` is high in the cycle that follows clock edge 34+k, where the accepting edge is edge 0 and k = 16*prescaler index + scaler index of the pair that is tested last.
- R8: `start` is accepted only while `busy` is low. A pulse of `start` while `busy` is high changes neither the running search nor its result.
- R9: `done`, `err` and `sat` are single-cycle pulses. `busy` is high from the cycle after an accepted non-zero start up to and including the cycle before `done`.
- R10: After reset, `busy`, `done`, `err` and `sat` are low and both indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a search, sampled while idle |
| clk_rate | input | 32 | Input clock rate |
| target_rate | input | 32 | Requested serial rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Pulses with done when target_rate was 0 |
| sat | output | 1 | Pulses with done when the fallback pair is used |
| pre_idx | output | 2 | Chosen prescaler index |
| scl_idx | output | 4 | Chosen scaler index |

## Verification
The bench targets exact ratio boundaries. A ratio of 64 must stop at pair (0,5) and a ratio of 65 must move on to (0,6). A comparison that uses strictly greater, or that drops the halving of the clock rate, returns the neighbouring pair. Ratios above 65536 are used to force the search into prescalers 3, 5 and 7, so a swapped loop order or a wrong prescaler factor picks the wrong index. A ratio of exactly 229376 must end at (3,15) without `sat`, while 229377 must saturate. A zero rate must leave the previous indices intact, and a start that arrives during a search must not disturb it. The bench models every cycle, so an off-by-one in divider or scan latency shows up as a `done` in the wrong cycle.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;

    // Width of a factor product; 7 * 32768 needs 18 bits
    localparam int PROD_W = 18;
    localparam int PRE_W  = 2;
    localparam int SCL_W  = 4;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SCL_W-1:0] scl;
    } pair_t;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    function automatic logic [PROD_W-1:0] pre_factor(input logic [PRE_W-1:0] i);
        case (i)
            2'd0:    return PROD_W'(2);
            2'd1:    return PROD_W'(3);
            2'd2:    return PROD_W'(5);
            default: return PROD_W'(7);
        endcase
    endfunction

    function automatic logic [PROD_W-1:0] scl_factor(input logic [SCL_W-1:0] i);
        if (i < SCL_W'(4))
            return PROD_W'({i, 1'b0}) + PROD_W'(2);
        else
            return PROD_W'(1) << i;
    endfunction

    function automatic logic [PROD_W-1:0] pair_product(input pair_t p);
        return PROD_W'(pre_factor(p.pre) * scl_factor(p.scl));
    endfunction

endpackage

// File: rtl/baud_ratio_div.sv
module baud_ratio_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         running,
    output logic         valid,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     dvd_q;
    logic [W-1:0]     dvs_q;
    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [CNT_W-1:0] cnt_q;

    logic [W:0]   rem_sh;
    logic [W-1:0] rem_nxt;
    logic         q_bit;

    always_comb begin
        rem_sh = {rem_q, dvd_q[W-1]};
        if (rem_sh >= {1'b0, dvs_q}) begin
            rem_nxt = W'(rem_sh - {1'b0, dvs_q});
            q_bit   = 1'b1;
        end else begin
            rem_nxt = rem_sh[W-1:0];
            q_bit   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q   <= '0;
            dvs_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            cnt_q   <= '0;
            running <= 1'b0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (load) begin
                dvd_q   <= dividend;
                dvs_q   <= divisor;
                rem_q   <= '0;
                quo_q   <= '0;
                cnt_q   <= '0;
                running <= 1'b1;
            end else if (running) begin
                dvd_q <= dvd_q << 1;
                rem_q <= rem_nxt;
                quo_q <= {quo_q[W-2:0], q_bit};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    running <= 1'b0;
                    valid   <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // R7: the divider hands over exactly once per run
    assert_div_handover_R7: assert property (@(posedge clk) disable iff (rst)
        valid |-> !running && !$past(valid));

    // R1: remainder never reaches the divisor during a run
    assert_rem_bound_R1: assert property (@(posedge clk) disable iff (rst)
        running && !$past(load) |-> rem_q < dvs_q);

endmodule

// File: rtl/baud_pair_scan.sv
module baud_pair_scan
    import baud_search_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] ratio,
    output logic         active,
    output logic         done,
    output logic         sat,
    output pair_t        result
);
    scan_state_e state_q;
    logic [W-1:0] ratio_q;
    pair_t        cur_q;
    logic         fits;

    assign fits   = W'(pair_product(cur_q)) >= ratio_q;
    assign active = (state_q == SCAN_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            ratio_q <= '0;
            cur_q   <= '0;
            result  <= '0;
            done    <= 1'b0;
            sat     <= 1'b0;
        end else begin
            done <= 1'b0;
            sat  <= 1'b0;
            case (state_q)
                SCAN_IDLE: begin
                    if (go) begin
                        ratio_q <= ratio;
                        cur_q   <= '0;
                        state_q <= SCAN_RUN;
                    end
                end
                default: begin
                    if (fits) begin
                        result  <= cur_q;
                        done    <= 1'b1;
                        state_q <= SCAN_IDLE;
                    end else if (&cur_q) begin
                        result  <= cur_q;
                        sat     <= 1'b1;
                        done    <= 1'b1;
                        state_q <= SCAN_IDLE;
                    end else begin
                        // scaler is the low field: carry steps the prescaler
                        cur_q <= pair_t'(cur_q + 1'b1);
                    end
                end
            endcase
        end
    end

    // R5: fallback always reports the largest pair
    assert_sat_max_R5: assert property (@(posedge clk) disable iff (rst)
        sat |-> done && (&result.pre) && (&result.scl));

    // R4: a hit meets the ratio and its predecessor in search order did not
    assert_first_fit_R4: assert property (@(posedge clk) disable iff (rst)
        done && !sat && (result != '0) |->
            (W'(pair_product(result)) >= ratio_q) &&
            (W'(pair_product(pair_t'(result - 1'b1))) < ratio_q));

endmodule

// File: rtl/baud_search_engine.sv
module baud_search_engine
    import baud_search_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] clk_rate,
    input  logic [RATE_W-1:0] target_rate,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              sat,
    output logic [PRE_W-1:0]  pre_idx,
    output logic [SCL_W-1:0]  scl_idx
);
    logic              accept;
    logic              zero_rate;
    logic              div_running;
    logic              div_valid;
    logic [RATE_W-1:0] ratio;
    logic              scan_active;
    logic              scan_done;
    logic              scan_sat;
    pair_t             pick;
    logic              err_q;

    assign busy      = div_running | div_valid | scan_active;
    assign zero_rate = (target_rate == '0);
    assign accept    = start && !busy;

    baud_ratio_div #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && !zero_rate),
        .dividend (clk_rate >> 1),
        .divisor  (target_rate),
        .running  (div_running),
        .valid    (div_valid),
        .quotient (ratio)
    );

    baud_pair_scan #(.W(RATE_W)) u_scan (
        .clk    (clk),
        .rst    (rst),
        .go     (div_valid),
        .ratio  (ratio),
        .active (scan_active),
        .done   (scan_done),
        .sat    (scan_sat),
        .result (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= accept && zero_rate;
    end

    assign done    = scan_done | err_q;
    assign err     = err_q;
    assign sat     = scan_sat;
    assign pre_idx = pick.pre;
    assign scl_idx = pick.scl;

    // R9: completion is a single-cycle pulse and ends the busy window
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6: a refused request keeps the indices and never looks busy
    assert_err_keeps_idx_R6: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(pre_idx) && $stable(scl_idx) && !busy && !sat);

    // R8: a start during a search cannot produce a refusal
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> !err);

endmodule

// File: tb/tb_baud_search_engine.sv
module tb_baud_search_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] clk_rate = '0;
    logic [31:0] target_rate = '0;
    logic        busy, done, err, sat;
    logic [1:0]  pre_idx;
    logic [3:0]  scl_idx;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    baud_search_engine dut (
        .clk(clk), .rst(rst), .start(start), .clk_rate(clk_rate),
        .target_rate(target_rate), .busy(busy), .done(done), .err(err),
        .sat(sat), .pre_idx(pre_idx), .scl_idx(scl_idx)
    );

    int pre_tab [4]  = '{2, 3, 5, 7};
    int scl_tab [16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512,
                         1024, 2048, 4096, 8192, 16384, 32768};

    // reference search: R1, R2, R3, R4, R5
    function automatic void ref_pair(input longint unsigned c, input longint unsigned r,
                                     output int k, output bit s);
        longint unsigned need;
        need = (c / 2) / r;
        s = 1'b1;
        k = 63;
        for (int i = 0; i < 64; i++) begin
            if (longint'(pre_tab[i / 16]) * longint'(scl_tab[i % 16]) >= longint'(need)) begin
                k = i;
                s = 1'b0;
                break;
            end
        end
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // cycle-by-cycle model
    bit m_busy, m_done, m_err, m_sat;
    int m_cnt, m_k, m_pre, m_scl;
    bit m_pend_sat;

    always @(posedge clk) begin
        cycles++;
        m_done = 0; m_err = 0; m_sat = 0;
        if (rst) begin
            m_busy = 0; m_pre = 0; m_scl = 0; m_cnt = 0;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_busy = 0;
                m_done = 1;
                m_sat  = m_pend_sat;
                m_pre  = m_k / 16;
                m_scl  = m_k % 16;
            end
        end else if (start) begin
            if (target_rate == 0) begin
                m_done = 1;
                m_err  = 1;
            end else begin
                ref_pair(longint'(clk_rate), longint'(target_rate), m_k, m_pend_sat);
                m_busy = 1;
                m_cnt  = 34 + m_k;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(busy == m_busy, "R9 busy", busy, m_busy);
            check(done == m_done, "R7 done timing", done, m_done);
            check(err == m_err, "R6 err", err, m_err);
            check(sat == m_sat, "R5 sat", sat, m_sat);
            check(pre_idx == m_pre, "R4 pre_idx", pre_idx, m_pre);
            check(scl_idx == m_scl, "R4 scl_idx", scl_idx, m_scl);
        end
    end

    // one search with explicit result checks; inject>0 pulses a zero-rate start mid-run
    task automatic run_op(input logic [31:0] c, input logic [31:0] r, input int inject,
                          input string tag);
        int k, n;
        bit s;
        logic [1:0] old_pre;
        logic [3:0] old_scl;
        old_pre = pre_idx;
        old_scl = scl_idx;
        if (r != 0) ref_pair(longint'(c), longint'(r), k, s);
        else begin k = 0; s = 0; end
        clk_rate = c; target_rate = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            if (inject == n) begin
                start = 1'b1; target_rate = 32'd0; clk_rate = 32'hFFFF_FFFF;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (r == 0) begin
            check(n == 1, {tag, " R6 latency"}, n, 1);
            check(err == 1'b1, {tag, " R6 err"}, err, 1);
            check(pre_idx == old_pre && scl_idx == old_scl, {tag, " R6 idx held"},
                  {pre_idx, scl_idx}, {old_pre, old_scl});
        end else begin
            check(n == 35 + k, {tag, " R7 latency"}, n, 35 + k);
            check(pre_idx == k / 16, {tag, " R4 pre"}, pre_idx, k / 16);
            check(scl_idx == k % 16, {tag, " R4 scl"}, scl_idx, k % 16);
            check(sat == s, {tag, " R5 sat"}, sat, s);
            check(err == 1'b0, {tag, " R8 no err"}, err, 0);
        end
        @(negedge clk);
        check(!done && !sat && !err, {tag, " R9 pulse"}, {done, sat, err}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !err && !sat, "R10 flags", {busy, done, err, sat}, 0);
        check(pre_idx == 0 && scl_idx == 0, "R10 idx", {pre_idx, scl_idx}, 0);

        run_op(32'd100_000_000, 32'd1_000_000, 0, "ratio50");   // R4 k=5
        run_op(32'd2, 32'd1, 0, "ratio1");                      // R4 (0,0)
        run_op(32'd128, 32'd1, 0, "ratio64");                   // R4 exact 2*32
        run_op(32'd130, 32'd1, 0, "ratio65");                   // R4 step to (0,6)
        run_op(32'd129, 32'd1, 0, "odd129");                    // R1 halving -> 64
        run_op(32'd131, 32'd1, 0, "odd131");                    // R1 -> 65
        run_op(32'd14, 32'd1, 0, "ratio7");                     // R3 factor 8
        run_op(32'd140_000, 32'd1, 0, "pre3");                  // R2 prescaler 3
        run_op(32'd200_000_000, 32'd1000, 0, "pre5");           // R2 prescaler 5
        run_op(32'd458_752, 32'd1, 0, "exact_max");             // R5 exact (3,15) no sat
        run_op(32'd1_000_000, 32'd0, 0, "zero_rate");           // R6
        run_op(32'd458_754, 32'd1, 0, "sat_edge");              // R5 saturate
        run_op(32'hFFFF_FFFF, 32'd1, 0, "sat_big");             // R5
        run_op(32'd600_000, 32'd7, 0, "div7");                  // R1 ratio 42857
        run_op(32'd0, 32'd5, 0, "zero_clk");                    // R4 (0,0)
        run_op(32'd50_000_000, 32'd9600, 10, "inject");         // R8 ignored start
        run_op(32'd50_000_000, 32'd9600, 40, "inject_scan");    // R8 during scan
        run_op(32'd1_000, 32'd0, 0, "zero_after");              // R6 idx held

        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule